// File: doc/BRIEF.md
# Subroutine Return Address Stack

This block owns the program counter and the return stack of a small 8-bit controller. The stack is kept in a fixed window of the general data RAM, which the block reaches through a single byte-wide port. A call, or an interrupt vector presented as a call, saves the current program counter together with the four upper status flags as a two-byte entry. The program counter then takes the call target. A return reads an entry back. One return variant restores the saved flags along with the address. The other restores the address only.

A 3-bit stack pointer picks one of eight entries. The same pointer forms the low three bits of an 8-bit status word, so software that reads or writes the status word sees and sets the pointer. The pointer wraps silently in both directions, and once more than eight calls are nested the oldest entry is overwritten. Each transfer takes several cycles. During that time a busy output is high and new strobes are ignored.

Top module: `retstk_top`

## Requirements
- R1: While reset is held (synchronous, active high), the block clears the program counter, stack pointer, flags and RAM strobes. After reset the status word reads 0x08 and busy is low.
- R2: Entry k (pointer value k) occupies RAM bytes STK_BASE+2k and STK_BASE+2k+1, with STK_BASE = 8 by default. The even byte holds PC[7:0]. The odd byte holds status[7:4] in bits 7:4 and PC[11:8] in bits 3:0.
- R3: A call accepted at an edge drives two RAM write cycles on the next two cycles, even byte first, at the entry the pointer held before the call. The pointer then advances by one, and the program counter equals the call target. Busy is high for exactly two cycles.
- R4: A return first decrements the pointer. It then reads the even byte and the odd byte of the entry the pointer now selects, on two consecutive read cycles. RAM read data is taken one cycle after each read strobe. Busy is high for exactly three cycles, and the program counter is then the saved address.
- R5: A call with pointer 7 leaves pointer 0, and a return with pointer 0 uses entry 7. Nothing is flagged, and a ninth nested call overwrites the oldest entry.
- R6: The flag-restoring return loads status[7:4] from the odd byte. The plain return leaves status[7:4] unchanged.
- R7: Status bit 3 always reads 1, whatever value was written to it.
- R8: A status write loads status[7:4] into the flags and status[2:0] into the pointer. The new value is visible the cycle after the strobe.
- R9: Call, return and status-write strobes that arrive while busy is high are ignored. They do not change the pointer, the flags or the program counter.
- R10: When several strobes are high in the same idle cycle, only one is taken. The order is call first, then flag-restoring return, then plain return, then status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call / interrupt vector strobe |
| call_addr | input | 12 | Call target address |
| ret_req | input | 1 | Return strobe that keeps the flags |
| retr_req | input | 1 | Return strobe that restores the flags |
| psw_wr | input | 1 | Status word write strobe |
| psw_wdata | input | 8 | Status word write value |
| psw_rd | output | 8 | Status word: flags, constant 1, pointer |
| pc_out | output | 12 | Program counter |
| busy | output | 1 | Stack transfer in progress |
| ram_we | output | 1 | Data RAM write strobe |
| ram_re | output | 1 | Data RAM read strobe |
| ram_addr | output | 8 | Data RAM byte address |
| ram_wdata | output | 8 | Data RAM write byte |
| ram_rdata | input | 8 | Data RAM read byte, valid one cycle after ram_re |

## Verification
The bench nests ten calls, so the pointer wraps past 7 and overwrites the two oldest entries. It then unwinds through underflow with alternating return kinds. An off-by-one pointer ordering would write one entry too high or return to the wrong address. A design that wrapped wrongly would lose the overwritten entries in a different order than expected. Swapped byte halves or a misplaced flag nibble would show up in the RAM bytes and in the restored status word. The bench also holds strobes high during a transfer and fires several strobes at once. A design that queued strobes or used the wrong priority would end with the wrong pointer or the wrong flags.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_END,
    ST_POP_HI,
    ST_POP_CAP,
    ST_POP_END
  } stk_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CALL,
    OP_RETR,
    OP_RET,
    OP_PSW
  } stk_op_e;

endpackage

// File: rtl/retstk_ptr.sv
module retstk_ptr #(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_dn
);

  // power-of-two depth: modulo arithmetic gives the silent wrap
  assign sp_dn = sp - SP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (load) sp <= load_val;
    else if (inc)  sp <= sp + SP_W'(1);
    else if (dec)  sp <= sp_dn;
  end

endmodule

// File: rtl/retstk_seq.sv
module retstk_seq
  import retstk_pkg::*;
#(
  parameter int PC_W     = 12,
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int FLAG_W   = 4,
  parameter int SP_W     = 3,
  parameter int STK_BASE = 8,
  localparam int PCHI_W  = PC_W - DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_req,
  input  logic [PC_W-1:0]   call_addr,
  input  logic              ret_req,
  input  logic              retr_req,
  input  logic              psw_wr,
  input  logic [FLAG_W-1:0] psw_flags,
  input  logic [SP_W-1:0]   sp,
  input  logic [SP_W-1:0]   sp_dn,
  input  logic [DW-1:0]     ram_rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              busy,
  output logic [PC_W-1:0]   pc,
  output logic [FLAG_W-1:0] flags,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              sp_load
);

  stk_state_e st_q;
  stk_op_e    op;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] lo_q;
  logic          restore_q;

  function automatic logic [AW-1:0] slot_addr(input logic [SP_W-1:0] p);
    return AW'(STK_BASE) + AW'({p, 1'b0});
  endfunction

  // one request per idle cycle, fixed priority
  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (call_req)      op = OP_CALL;
      else if (retr_req) op = OP_RETR;
      else if (ret_req)  op = OP_RET;
      else if (psw_wr)   op = OP_PSW;
    end
  end

  assign sp_inc  = (st_q == ST_PUSH_END);
  assign sp_dec  = (op == OP_RET) || (op == OP_RETR);
  assign sp_load = (op == OP_PSW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      busy      <= 1'b0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      pc        <= '0;
      flags     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      restore_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          case (op)
            OP_CALL: begin
              ram_we    <= 1'b1;
              ram_addr  <= slot_addr(sp);
              ram_wdata <= pc[DW-1:0];
              hi_q      <= {flags, pc[PC_W-1:DW]};
              pc        <= call_addr;
              busy      <= 1'b1;
              st_q      <= ST_PUSH_HI;
            end
            OP_RET, OP_RETR: begin
              ram_re    <= 1'b1;
              ram_addr  <= slot_addr(sp_dn);
              restore_q <= (op == OP_RETR);
              busy      <= 1'b1;
              st_q      <= ST_POP_HI;
            end
            OP_PSW: flags <= psw_flags;
            default: ;
          endcase
        end
        ST_PUSH_HI: begin
          ram_addr  <= ram_addr + AW'(1);
          ram_wdata <= hi_q;
          st_q      <= ST_PUSH_END;
        end
        ST_PUSH_END: begin
          ram_we <= 1'b0;
          busy   <= 1'b0;
          st_q   <= ST_IDLE;
        end
        ST_POP_HI: begin
          ram_addr <= ram_addr + AW'(1);
          st_q     <= ST_POP_CAP;
        end
        ST_POP_CAP: begin
          ram_re <= 1'b0;
          lo_q   <= ram_rdata;
          st_q   <= ST_POP_END;
        end
        ST_POP_END: begin
          pc <= {ram_rdata[PCHI_W-1:0], lo_q};
          if (restore_q) flags <= ram_rdata[DW-1 -: FLAG_W];
          busy <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/retstk_top.sv
module retstk_top #(
  parameter int PC_W     = 12,
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int FLAG_W   = 4,
  parameter int DEPTH    = 8,
  parameter int STK_BASE = 8,
  localparam int SP_W    = $clog2(DEPTH),
  localparam int PSW_W   = FLAG_W + 1 + SP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic [PC_W-1:0]  call_addr,
  input  logic             ret_req,
  input  logic             retr_req,
  input  logic             psw_wr,
  input  logic [PSW_W-1:0] psw_wdata,
  output logic [PSW_W-1:0] psw_rd,
  output logic [PC_W-1:0]  pc_out,
  output logic             busy,
  output logic             ram_we,
  output logic             ram_re,
  output logic [AW-1:0]    ram_addr,
  output logic [DW-1:0]    ram_wdata,
  input  logic [DW-1:0]    ram_rdata
);

  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   sp_dn;
  logic [FLAG_W-1:0] flags;
  logic              sp_inc;
  logic              sp_dec;
  logic              sp_load;
  logic              psw_unused;

  assign psw_unused = psw_wdata[SP_W];

  retstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .inc      (sp_inc),
    .dec      (sp_dec),
    .load     (sp_load),
    .load_val (psw_wdata[SP_W-1:0]),
    .sp       (sp),
    .sp_dn    (sp_dn)
  );

  retstk_seq #(
    .PC_W(PC_W), .DW(DW), .AW(AW), .FLAG_W(FLAG_W),
    .SP_W(SP_W), .STK_BASE(STK_BASE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .call_req  (call_req),
    .call_addr (call_addr),
    .ret_req   (ret_req),
    .retr_req  (retr_req),
    .psw_wr    (psw_wr),
    .psw_flags (psw_wdata[PSW_W-1 -: FLAG_W]),
    .sp        (sp),
    .sp_dn     (sp_dn),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .busy      (busy),
    .pc        (pc_out),
    .flags     (flags),
    .sp_inc    (sp_inc),
    .sp_dec    (sp_dec),
    .sp_load   (sp_load)
  );

  assign psw_rd = {flags, 1'b1, sp};

endmodule

// File: rtl/retstk_chk.sv
module retstk_chk #(
  parameter int PC_W     = 12,
  parameter int AW       = 8,
  parameter int PSW_W    = 8,
  parameter int SP_W     = 3,
  parameter int DEPTH    = 8,
  parameter int STK_BASE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             ram_we,
  input logic             ram_re,
  input logic [AW-1:0]    ram_addr,
  input logic [PSW_W-1:0] psw_rd,
  input logic [PC_W-1:0]  pc_out
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_STATE: assert (pc_out == '0 && psw_rd[SP_W-1:0] == '0 && !busy && !ram_we && !ram_re) // R1
        else $error("reset state wrong");
    end
  end

  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> (ram_addr >= AW'(STK_BASE) && ram_addr <= AW'(STK_BASE + 2*DEPTH - 1))); // R2

  AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we) |-> (ram_addr[0] == 1'b0)); // R2

  AST_PAIR_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we) |=> (ram_we && ram_addr == $past(ram_addr) + AW'(1))); // R3

  AST_TWO_WRITES: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |=> !ram_we); // R3

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ram_we && !ram_re)); // R4

  AST_PC_ONLY_AT_EDGES: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> ($rose(busy) || $fell(busy))); // R9

endmodule

bind retstk_top retstk_chk #(
  .PC_W(PC_W), .AW(AW), .PSW_W(PSW_W), .SP_W(SP_W),
  .DEPTH(DEPTH), .STK_BASE(STK_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .ram_we   (ram_we),
  .ram_re   (ram_re),
  .ram_addr (ram_addr),
  .psw_rd   (psw_rd),
  .pc_out   (pc_out)
);

// File: tb/tb_retstk_top.sv
module tb_retstk_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        call_req = 0, ret_req = 0, retr_req = 0, psw_wr = 0;
  logic [11:0] call_addr = '0;
  logic [7:0]  psw_wdata = '0;
  logic [7:0]  psw_rd;
  logic [11:0] pc_out;
  logic        busy, ram_we, ram_re;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;

  retstk_top dut (
    .clk(clk), .rst(rst), .call_req(call_req), .call_addr(call_addr),
    .ret_req(ret_req), .retr_req(retr_req), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
    .psw_rd(psw_rd), .pc_out(pc_out), .busy(busy), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [7:0] mem [256];
  logic [7:0] rdq = '0;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) rdq <= mem[ram_addr];
  end
  assign ram_rdata = rdq;

  int total = 0, bad = 0;
  logic [11:0] e_pc;
  logic [2:0]  e_sp;
  logic [3:0]  e_fl;
  logic [15:0] stk [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_psw();
    return {e_fl, 1'b1, e_sp};
  endfunction

  task automatic check_state(input string req);
    chk(pc_out == e_pc, req, pc_out, e_pc);
    chk(psw_rd == e_psw(), req, psw_rd, e_psw());
    chk(!busy, req, busy, 0);
  endtask

  task automatic psw_write(input logic [7:0] v);
    @(negedge clk); psw_wr = 1; psw_wdata = v;
    @(negedge clk); psw_wr = 0;
    e_fl = v[7:4]; e_sp = v[2:0];
    check_state("R8");
    chk(psw_rd[3] == 1'b1, "R7", psw_rd[3], 1);
  endtask

  task automatic do_call(input logic [11:0] a);
    logic [7:0] base;
    string rq;
    rq = (e_sp == 3'd7) ? "R5" : "R3";
    base = 8'd8 + {4'd0, e_sp, 1'b0};
    @(negedge clk); call_req = 1; call_addr = a;
    @(negedge clk); call_req = 0;
    chk(ram_we && busy && ram_addr == base && ram_wdata == e_pc[7:0], "R3",
        {ram_we, busy, ram_addr, ram_wdata}, {2'b11, base, e_pc[7:0]});
    @(negedge clk);
    chk(ram_we && busy && ram_addr == base + 8'd1 && ram_wdata == {e_fl, e_pc[11:8]}, "R2",
        {ram_we, busy, ram_addr, ram_wdata}, {2'b11, base + 8'd1, e_fl, e_pc[11:8]});
    @(negedge clk);
    stk[e_sp] = {e_fl, e_pc};
    e_pc = a; e_sp = e_sp + 3'd1;
    check_state(rq);
    chk(!ram_we, "R3", ram_we, 0);
  endtask

  task automatic do_ret(input bit restore);
    logic [7:0] base;
    string rq;
    rq = (e_sp == 3'd0) ? "R5" : "R4";
    e_sp = e_sp - 3'd1;
    base = 8'd8 + {4'd0, e_sp, 1'b0};
    @(negedge clk); if (restore) retr_req = 1; else ret_req = 1;
    @(negedge clk); retr_req = 0; ret_req = 0;
    chk(ram_re && busy && ram_addr == base, rq, {ram_re, busy, ram_addr}, {2'b11, base});
    @(negedge clk);
    chk(ram_re && busy && ram_addr == base + 8'd1, "R4", {ram_re, busy, ram_addr}, {2'b11, base + 8'd1});
    @(negedge clk);
    chk(busy, "R4", busy, 1);
    @(negedge clk);
    e_pc = stk[e_sp][11:0];
    if (restore) e_fl = stk[e_sp][15:12];
    check_state(restore ? "R6" : "R6_plain");
  endtask

  task automatic fire(input bit c, input bit rr, input bit r, input bit p,
                      input logic [11:0] a, input logic [7:0] v);
    @(negedge clk); call_req = c; retr_req = rr; ret_req = r; psw_wr = p;
    call_addr = a; psw_wdata = v;
    @(negedge clk); call_req = 0; retr_req = 0; ret_req = 0; psw_wr = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    e_pc = '0; e_sp = '0; e_fl = '0;
    check_state("R1");
    chk(!ram_we && !ram_re, "R1", {ram_we, ram_re}, 0);
    chk(psw_rd == 8'h08, "R1", psw_rd, 8'h08);

    psw_write(8'hF5);
    psw_write(8'h00);

    for (int i = 0; i < 10; i++) begin
      psw_write({4'(i * 5 + 3), 1'(i), e_sp});
      do_call(12'h0A3 + 12'(i * 12'h151));
    end
    for (int i = 0; i < 10; i++) begin
      psw_write({4'(~i), 1'b0, e_sp});
      do_ret(i[0]);
    end

    // R9: strobes held while busy are dropped
    @(negedge clk); call_req = 1; call_addr = 12'h3C5;
    @(negedge clk); call_req = 0; ret_req = 1; retr_req = 1; psw_wr = 1; psw_wdata = 8'h07;
    @(negedge clk);
    @(negedge clk); ret_req = 0; retr_req = 0; psw_wr = 0;
    stk[e_sp] = {e_fl, e_pc}; e_pc = 12'h3C5; e_sp = e_sp + 3'd1;
    repeat (2) @(negedge clk);
    check_state("R9");

    // R10: priority among simultaneous strobes
    fire(1, 1, 1, 1, 12'h777, 8'h02);
    stk[e_sp] = {e_fl, e_pc}; e_pc = 12'h777; e_sp = e_sp + 3'd1;
    check_state("R10");
    psw_write({4'h9, 1'b0, e_sp});
    fire(0, 1, 1, 1, 12'h000, 8'h03);
    e_sp = e_sp - 3'd1; e_pc = stk[e_sp][11:0]; e_fl = stk[e_sp][15:12];
    check_state("R10");
    psw_write({4'h6, 1'b0, e_sp});
    fire(0, 0, 1, 1, 12'h000, 8'h03);
    e_sp = e_sp - 3'd1; e_pc = stk[e_sp][11:0];
    check_state("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule